// File: doc/BRIEF.md
# Serial Line Transmitter with Break Generation

This block drives an asynchronous serial line, one byte per frame: a low start bit, eight data bits with the least significant bit first, then a high stop bit. A one-byte holding stage sits in front of the frame shifter, so the next byte can be queued while the current frame is still on the line. When a byte is queued at the end of a stop bit, the next frame follows with no idle time.

The block can also send a long low break symbol, as a bus master does to open a message header. Software raises a break request and then writes any dummy byte. When that byte moves into the shifter while the request is set, the block ignores its value and sends a start bit, twelve low bit periods and a stop bit. The request clears itself when that stop bit ends. The byte queued behind the break, usually the 55h sync pattern, then goes out as an ordinary frame with no gap. Bit timing comes from an internal clock divider or from an external tick, chosen by a parameter.

Top module: `lin_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `shift_idle` is 1 and `brk_pending` is 0.
- R2: An ordinary frame is one 0 start bit, the 8 data bits with bit 0 first, and one 1 stop bit. Each bit lasts one tick period, which is DIV clock cycles with the internal divider. `txd` is 1 while no frame is shifting.
- R3: A break frame is 13 consecutive low bit periods (the start bit plus twelve zeros) followed by one high stop bit. The value of the byte that triggered it has no effect on the line.
- R4: The break request is sampled only when a byte moves from the holding stage into the shifter. Raising it while an ordinary frame is shifting leaves that frame unchanged and turns the next loaded byte into a break.
- R5: `brk_pending` goes to 1 on a `brk_set` pulse and returns to 0 by itself at the end of the break frame's stop bit.
- R6: A byte queued while a break is shifting is sent as an ordinary frame right after the break's stop bit, with no idle period.
- R7: When the holding stage is full as a stop bit ends, the next frame's start bit follows immediately.
- R8: `buf_empty` is 1 exactly when the holding stage is free. A write while it is full is ignored and the queued byte is kept.
- R9: `shift_idle` is 0 while any frame, break or ordinary, is shifting, and 1 otherwise.
- R10: While `tx_en` is 0, `txd` is held at 1 and the shifter is reset, so `shift_idle` is 1 one cycle after enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable |
| ext_tick | input | 1 | External bit-rate tick, used when USE_EXT_TICK is set |
| brk_set | input | 1 | Pulse that raises the break request |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to queue |
| brk_pending | output | 1 | Break request bit, cleared by hardware |
| buf_empty | output | 1 | Holding stage is free |
| shift_idle | output | 1 | No frame is shifting |
| txd | output | 1 | Serial line |

## Verification
A behavioural reference model is compared against all four outputs on every clock. The stimulus includes a single queued byte while the block is disabled, with a second write that must be dropped. It also includes three bytes written as soon as space frees up, which shows whether back-to-back frames run gap-free. A break with an all-ones dummy byte followed by 55h is decoded by the lengths of the low runs on the line. This tells a correct 13-bit break apart from a shortened one, from one that leaks the dummy data, and from one with a gap before the sync byte. A break raised in the middle of an ordinary frame, and an enable dropped mid-frame, check when the request is sampled and how the shifter resets.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
    localparam int DATA_W    = 8;
    localparam int BRK_ZEROS = 12;
    localparam int NORM_LEN  = DATA_W + 2;
    localparam int BRK_LEN   = BRK_ZEROS + 2;
    localparam int FRAME_MAX = (BRK_LEN > NORM_LEN) ? BRK_LEN : NORM_LEN;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef logic [DATA_W-1:0]    byte_t;
    typedef logic [FRAME_MAX-1:0] frame_t;
    typedef logic [CNT_W-1:0]     bitcnt_t;

    // Frame in flight: bits go out from bit 0, left counts bits still owed.
    typedef struct packed {
        frame_t  bits;
        bitcnt_t left;
        logic    is_brk;
    } shift_t;

    function automatic frame_t build_frame(byte_t d, logic brk);
        frame_t f;
        if (brk) f = frame_t'({1'b1, {BRK_ZEROS{1'b0}}, 1'b0});
        else     f = frame_t'({1'b1, d, 1'b0});
        return f;
    endfunction

    function automatic bitcnt_t frame_len(logic brk);
        return brk ? bitcnt_t'(BRK_LEN) : bitcnt_t'(NORM_LEN);
    endfunction
endpackage

// File: rtl/lin_tx_baud.sv
module lin_tx_baud #(
    parameter int DIV          = 16,
    parameter bit USE_EXT_TICK = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ext_tick,
    output logic tick
);
    localparam int CW = $clog2(DIV > 1 ? DIV : 2);

    generate
        if (USE_EXT_TICK) begin : g_ext
            logic unused_sig;
            assign unused_sig = clk ^ rst;
            assign tick = en & ext_tick;
        end else begin : g_div
            logic [CW-1:0] cnt;
            logic          unused_sig;
            assign unused_sig = ext_tick;
            assign tick = en && (cnt == CW'(DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || !en) cnt <= '0;
                else if (tick)  cnt <= '0;
                else            cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/lin_tx_hold.sv
module lin_tx_hold
    import lin_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_valid,
    input  byte_t wr_data,
    input  logic  pop,
    output logic  full,
    output byte_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (pop) full <= 1'b0;
            if (wr_valid && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/lin_tx_shift.sv
module lin_tx_shift
    import lin_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  tick,
    input  logic  hold_full,
    input  byte_t hold_data,
    input  logic  brk_req,
    output logic  pop,
    output logic  brk_done,
    output logic  active,
    output logic  txd
);
    shift_t cur;
    logic   last_bit;
    logic   brk_now;

    assign active   = (cur.left != '0);
    assign last_bit = (cur.left == bitcnt_t'(1));
    assign brk_done = tick && active && last_bit && cur.is_brk;
    assign pop      = en && tick && hold_full && (!active || last_bit);
    // A request being retired on this very tick must not apply to the next byte.
    assign brk_now  = brk_req && !brk_done;
    assign txd      = active ? cur.bits[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cur <= '0;
        end else if (pop) begin
            cur.bits   <= build_frame(hold_data, brk_now);
            cur.left   <= frame_len(brk_now);
            cur.is_brk <= brk_now;
        end else if (tick && active) begin
            cur.bits   <= cur.bits >> 1;
            cur.left   <= cur.left - 1'b1;
            cur.is_brk <= last_bit ? 1'b0 : cur.is_brk;
        end
    end
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
    import lin_tx_pkg::*;
#(
    parameter int DIV          = 16,
    parameter bit USE_EXT_TICK = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       ext_tick,
    input  logic       brk_set,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       brk_pending,
    output logic       buf_empty,
    output logic       shift_idle,
    output logic       txd
);
    logic  tick;
    logic  hold_full;
    byte_t hold_data;
    logic  pop;
    logic  brk_done;
    logic  active;

    lin_tx_baud #(.DIV(DIV), .USE_EXT_TICK(USE_EXT_TICK)) u_baud (
        .clk(clk), .rst(rst), .en(tx_en), .ext_tick(ext_tick), .tick(tick)
    );

    lin_tx_hold u_hold (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .pop(pop), .full(hold_full), .data(hold_data)
    );

    lin_tx_shift u_shift (
        .clk(clk), .rst(rst), .en(tx_en), .tick(tick),
        .hold_full(hold_full), .hold_data(hold_data), .brk_req(brk_pending),
        .pop(pop), .brk_done(brk_done), .active(active), .txd(txd)
    );

    always_ff @(posedge clk) begin
        if (rst)           brk_pending <= 1'b0;
        else if (brk_set)  brk_pending <= 1'b1;
        else if (brk_done) brk_pending <= 1'b0;
    end

    assign buf_empty  = !hold_full;
    assign shift_idle = !active;
endmodule

// File: rtl/lin_uart_tx_chk.sv
module lin_uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_valid,
    input logic brk_pending,
    input logic buf_empty,
    input logic shift_idle,
    input logic txd
);
    p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        shift_idle |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_idle) |-> !txd);

    p_disable_reset_r10: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (txd && shift_idle));

    p_write_fills_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_empty && wr_valid) |=> !buf_empty);

    p_brk_clear_on_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_pending) |-> $past(txd));
endmodule

bind lin_uart_tx lin_uart_tx_chk i_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_valid(wr_valid),
    .brk_pending(brk_pending), .buf_empty(buf_empty),
    .shift_idle(shift_idle), .txd(txd)
);

// File: tb/test_lin_uart_tx.sv
module test_lin_uart_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       ext_tick = 1'b0;
    logic       brk_set = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_pending, buf_empty, shift_idle, txd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_uart_tx #(.DIV(DIV), .USE_EXT_TICK(1'b0)) i_lin_uart_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .ext_tick(ext_tick),
        .brk_set(brk_set), .wr_valid(wr_valid), .wr_data(wr_data),
        .brk_pending(brk_pending), .buf_empty(buf_empty),
        .shift_idle(shift_idle), .txd(txd)
    );

    // ---------------- reference model ----------------
    int       mcnt = 0;
    bit       mbrk = 0;
    bit       mcur_brk = 0;
    bit       mline[$];
    bit [7:0] mhold[$];

    always @(posedge clk) begin
        bit tk, full_b, done, isb;
        bit [7:0] b;
        if (rst) begin
            mcnt = 0; mbrk = 0; mcur_brk = 0;
            mline.delete(); mhold.delete();
        end else begin
            tk = tx_en && (mcnt == DIV - 1);
            mcnt = (!tx_en || tk) ? 0 : mcnt + 1;
            full_b = (mhold.size() > 0);
            done = 0;
            if (!tx_en) begin
                mline.delete(); mcur_brk = 0;
            end else if (tk) begin
                if (mline.size() > 0) begin
                    void'(mline.pop_front());
                    if (mline.size() == 0 && mcur_brk) begin done = 1; mcur_brk = 0; end
                end
                if (mline.size() == 0 && mhold.size() > 0) begin
                    b = mhold.pop_front();
                    isb = mbrk && !done;
                    mline.push_back(1'b0);
                    if (isb) for (int i = 0; i < 12; i++) mline.push_back(1'b0);
                    else     for (int i = 0; i < 8; i++)  mline.push_back(b[i]);
                    mline.push_back(1'b1);
                    mcur_brk = isb;
                end
            end
            if (wr_valid && !full_b) mhold.push_back(wr_data);
            if (brk_set) mbrk = 1;
            else if (done) mbrk = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit exp_txd;
            exp_txd = (mline.size() > 0) ? mline[0] : 1'b1;
            check(txd == exp_txd, "R2/R3/R6/R7 txd", txd, exp_txd);
            check(buf_empty == (mhold.size() == 0), "R8 buf_empty", buf_empty, mhold.size() == 0);
            check(shift_idle == (mline.size() == 0), "R9 shift_idle", shift_idle, mline.size() == 0);
            check(brk_pending == mbrk, "R5 brk_pending", brk_pending, mbrk);
        end
    end

    // ---------------- low-run recorder ----------------
    bit rec = 0;
    int lowcnt = 0;
    int runs[$];

    always @(negedge clk) begin
        if (rec) begin
            if (txd == 1'b0) lowcnt++;
            else if (lowcnt > 0) begin runs.push_back(lowcnt); lowcnt = 0; end
        end
    end

    task automatic check_runs(input string req, input int exp[$]);
        bit ok;
        ok = (runs.size() == exp.size());
        for (int i = 0; ok && i < exp.size(); i++) if (runs[i] != exp[i]) ok = 0;
        check(ok, req, (runs.size() > 0) ? runs[0] : -1, exp[0]);
        if (!ok) $display("  runs seen %p expected %p", runs, exp);
    endtask

    // ---------------- stimulus ----------------
    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk); brk_set = 1'b1;
        @(negedge clk); brk_set = 1'b0;
    endtask

    task automatic wait_empty();
        do @(negedge clk); while (!buf_empty);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(buf_empty && shift_idle));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        check(shift_idle == 1'b1, "R1 shift_idle", shift_idle, 1);
        check(brk_pending == 1'b0, "R1 brk_pending", brk_pending, 0);

        // R8: second write while full is dropped (block disabled, R10 line high)
        write_byte(8'h3C);
        write_byte(8'hC3);
        check(buf_empty == 1'b0, "R8 full after write", buf_empty, 0);
        check(txd == 1'b1, "R10 line high while disabled", txd, 1);
        rec = 1; runs.delete(); lowcnt = 0;
        tx_en = 1'b1;
        wait_idle();
        // 3Ch lsb first: 0,0,0,1,1,1,1,0,0,1 -> low runs 3 bits, 2 bits
        check_runs("R2/R8 frame of 3Ch only", '{3*DIV, 2*DIV});

        // R7: back-to-back frames
        write_byte(8'hA5);
        wait_empty(); write_byte(8'h0F);
        wait_empty(); write_byte(8'h81);
        wait_idle();

        // R3/R5/R6: break with dummy FFh then 55h sync
        runs.delete(); lowcnt = 0;
        pulse_brk();
        check(brk_pending == 1'b1, "R5 request raised", brk_pending, 1);
        write_byte(8'hFF);
        wait_empty();
        write_byte(8'h55);
        wait_idle();
        check_runs("R3/R6 break then sync", '{13*DIV, DIV, DIV, DIV, DIV, DIV});
        check(brk_pending == 1'b0, "R5 request cleared", brk_pending, 0);

        // R4: request raised mid-frame applies to the next byte only
        runs.delete(); lowcnt = 0;
        write_byte(8'h12);
        do @(negedge clk); while (shift_idle);
        pulse_brk();
        write_byte(8'h34);
        wait_idle();
        check_runs("R4 sampled at transfer", '{2*DIV, 2*DIV, 3*DIV, 13*DIV});
        check(brk_pending == 1'b0, "R5 cleared after second break", brk_pending, 0);

        // R10: disable mid-frame
        rec = 0;
        write_byte(8'h77);
        do @(negedge clk); while (shift_idle);
        repeat (6) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R10 line high after disable", txd, 1);
        check(shift_idle == 1'b1, "R10 shifter reset", shift_idle, 1);
        repeat (5) @(negedge clk);
        tx_en = 1'b1;
        write_byte(8'hE7);
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule